// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits in front of a synchronous burst memory and produces the word address for each beat of a four-beat burst. On a rising clock edge it captures a start address when one of two address-status strobes arrives with the right chip enables. It then steps through the other three addresses of the burst, one step for each cycle in which the advance input is high. Only the two low address bits move. They follow either a linear count or an interleaved (XOR) pattern, picked by a mode input. The upper bits stay fixed for the whole burst.

The two strobes are qualified differently. The processor-side strobe counts only while the primary enable is high. The controller-side strobe counts whatever the primary enable is doing. When a qualified strobe arrives while the secondary enable is low, the block deselects: the valid flag drops. All outputs come from registers and change on the edge that samples the stimulus.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `addr_q` becomes 0, `valid_q` becomes 0 and `last_q` becomes 0.
- R2: If `cpu_ads`=1, `en_pri`=1 and `en_sec`=1 at an edge, then after that edge `addr_q` equals `addr_in`, `valid_q`=1 and `last_q`=0.
- R3: If `cpu_ads`=1, `en_pri`=0 and `ctl_ads`=0 at an edge, the strobe has no effect. Address, valid flag and last flag behave as if `cpu_ads` were 0.
- R4: If `ctl_ads`=1 and `en_sec`=1 at an edge, the address loads as in R2, whatever the value of `en_pri`.
- R5: If a qualified strobe (R2 or R4 gating) arrives with `en_sec`=0, then after that edge `valid_q`=0 and `last_q`=0, and `addr_q` holds.
- R6: If no qualified strobe arrives, `adv`=1 and `valid_q`=1, the burst steps one beat. In every other case `addr_q` and `last_q` hold. A qualified strobe takes priority over `adv`.
- R7: With `mode`=0 (linear), the low two address bits at beat k equal (start + k) mod 4. For example, start 1 gives 1,2,3,0.
- R8: With `mode`=1 (interleaved), the low two address bits at beat k equal start XOR k. For example, start 1 gives 1,0,3,2.
- R9: Address bits above bit 1 never change while the burst advances.
- R10: `last_q` is 1 exactly after the third advance following a load. The fourth advance wraps the beat count back to 0 and clears `last_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ads | input | 1 | Processor-side address strobe, gated by `en_pri` |
| ctl_ads | input | 1 | Controller-side address strobe, not gated by `en_pri` |
| en_pri | input | 1 | Primary chip enable, active high |
| en_sec | input | 1 | Secondary chip enable, active high; low means deselect |
| adv | input | 1 | Burst advance request |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Start address |
| addr_q | output | ADDR_W | Current word address |
| valid_q | output | 1 | A burst is selected |
| last_q | output | 1 | Current beat is the fourth of the burst |

## Verification
Each result is due on the first rising edge that samples its stimulus, with no further pipeline stage. A load, an advance or a deselect applied before edge N is visible on the outputs just after edge N. The bench changes inputs one time unit after an edge. It compares the outputs one time unit after the next edge, so every comparison falls between edges, exactly one cycle after its stimulus. Expected addresses come from the linear and XOR formulas applied to the start value the bench itself chose.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  function automatic logic [BEAT_W-1:0] beat_low(
    input logic [BEAT_W-1:0] base,
    input logic [BEAT_W-1:0] step,
    input order_e            ord
  );
    if (ord == ORD_INTERLEAVE) return base ^ step;
    return base + step;
  endfunction
endpackage

// File: rtl/bas_load_ctrl.sv
module bas_load_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cpu_ads,
  input  logic ctl_ads,
  input  logic en_pri,
  input  logic en_sec,
  input  logic adv,
  output logic load_go,
  output logic desel_go,
  output logic adv_go,
  output logic valid_q
);
  logic start;

  always_comb begin
    start    = (cpu_ads & en_pri) | ctl_ads;
    load_go  = start & en_sec;
    desel_go = start & ~en_sec;
    adv_go   = ~start & adv & valid_q;
  end

  always_ff @(posedge clk) begin
    if (rst)           valid_q <= 1'b0;
    else if (load_go)  valid_q <= 1'b1;
    else if (desel_go) valid_q <= 1'b0;
  end

  assert_load_sets_valid_R2: assert property (@(posedge clk) disable iff (rst)
    load_go |=> valid_q);
  assert_gated_strobe_no_effect_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_ads && !en_pri && !ctl_ads) |=> valid_q == $past(valid_q));
  assert_deselect_clears_R5: assert property (@(posedge clk) disable iff (rst)
    desel_go |=> !valid_q);
endmodule

// File: rtl/bas_burst_cnt.sv
module bas_burst_cnt #(
  parameter int CNT_W = bas_pkg::BEAT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_go,
  input  logic             desel_go,
  input  logic             adv_go,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             last_q
);
  localparam logic [CNT_W-1:0] LAST_BEAT = {CNT_W{1'b1}};

  assign cnt_nxt = CNT_W'(cnt_q + 1'b1);

  always_ff @(posedge clk) begin
    if (rst || load_go || desel_go) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (adv_go) begin
      cnt_q  <= cnt_nxt;
      last_q <= (cnt_nxt == LAST_BEAT);
    end
  end

  assert_step_by_one_R6: assert property (@(posedge clk) disable iff (rst)
    adv_go |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  assert_last_only_at_end_R10: assert property (@(posedge clk) disable iff (rst)
    last_q |-> cnt_q == LAST_BEAT);
  assert_load_restarts_R2: assert property (@(posedge clk) disable iff (rst)
    load_go |=> (cnt_q == '0) && !last_q);
endmodule

// File: rtl/bas_addr_gen.sv
module bas_addr_gen #(
  parameter int ADDR_W = 19
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_go,
  input  logic                       adv_go,
  input  logic                       mode,
  input  logic [bas_pkg::BEAT_W-1:0] cnt_nxt,
  input  logic [ADDR_W-1:0]          addr_in,
  output logic [ADDR_W-1:0]          addr_q
);
  import bas_pkg::*;
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [BEAT_W-1:0] base_lo;
  logic [BEAT_W-1:0] step_lo;

  assign step_lo = beat_low(base_lo, cnt_nxt, order_e'(mode));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo <= '0;
      addr_q  <= '0;
    end else if (load_go) begin
      base_lo <= addr_in[BEAT_W-1:0];
      addr_q  <= addr_in;
    end else if (adv_go) begin
      addr_q  <= {addr_q[ADDR_W-1:BEAT_W], step_lo};
    end
  end

  assert_upper_fixed_R9: assert property (@(posedge clk) disable iff (rst)
    adv_go |=> addr_q[ADDR_W-1:BEAT_W] == $past(addr_q[ADDR_W-1:BEAT_W]));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!load_go && !adv_go) |=> $stable(addr_q));
  assert_load_captures_R2: assert property (@(posedge clk) disable iff (rst)
    load_go |=> addr_q == $past(addr_in));
  initial assert (HI_W >= 1) else $error("address too narrow");
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_ads,
  input  logic              ctl_ads,
  input  logic              en_pri,
  input  logic              en_sec,
  input  logic              adv,
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              valid_q,
  output logic              last_q
);
  import bas_pkg::*;

  logic              load_go, desel_go, adv_go;
  logic [BEAT_W-1:0] cnt_q, cnt_nxt;

  bas_load_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cpu_ads(cpu_ads), .ctl_ads(ctl_ads),
    .en_pri(en_pri), .en_sec(en_sec), .adv(adv),
    .load_go(load_go), .desel_go(desel_go), .adv_go(adv_go), .valid_q(valid_q)
  );

  bas_burst_cnt #(.CNT_W(BEAT_W)) u_cnt (
    .clk(clk), .rst(rst), .load_go(load_go), .desel_go(desel_go), .adv_go(adv_go),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .last_q(last_q)
  );

  bas_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load_go(load_go), .adv_go(adv_go), .mode(mode),
    .cnt_nxt(cnt_nxt), .addr_in(addr_in), .addr_q(addr_q)
  );

  assert_ctl_ignores_pri_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_ads && en_sec) |=> valid_q && !last_q);
  assert_last_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
    last_q |-> valid_q);
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_ads = 0, ctl_ads = 0, en_pri = 0, en_sec = 0, adv = 0, mode = 0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_q;
  logic          valid_q, last_q;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk(clk), .rst(rst), .cpu_ads(cpu_ads), .ctl_ads(ctl_ads), .en_pri(en_pri),
    .en_sec(en_sec), .adv(adv), .mode(mode), .addr_in(addr_in),
    .addr_q(addr_q), .valid_q(valid_q), .last_q(last_q)
  );

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic t, input logic p, input logic s,
                     input logic a, input logic [AW-1:0] ad);
    cpu_ads = c; ctl_ads = t; en_pri = p; en_sec = s; adv = a; addr_in = ad;
    @(posedge clk); #1;
    cpu_ads = 0; ctl_ads = 0; adv = 0;
  endtask

  task automatic t_reset;
    rst = 1; @(posedge clk); @(posedge clk); #1;
    chk("R1 addr", addr_q, '0);
    chk("R1 valid", AW'(valid_q), '0);
    chk("R1 last", AW'(last_q), '0);
    rst = 0;
  endtask

  task automatic t_cpu_load;
    cyc(1, 0, 1, 1, 0, 19'h1_2345);
    chk("R2 addr", addr_q, 19'h1_2345);
    chk("R2 valid", AW'(valid_q), 1);
    chk("R2 last", AW'(last_q), 0);
  endtask

  task automatic t_cpu_gated;
    cyc(1, 0, 0, 1, 0, 19'h0_0AA8);
    chk("R3 addr held", addr_q, 19'h1_2345);
    chk("R3 valid held", AW'(valid_q), 1);
  endtask

  task automatic t_ctl_load;
    cyc(0, 1, 0, 1, 0, 19'h3_0F0E);
    chk("R4 addr", addr_q, 19'h3_0F0E);
    chk("R4 valid", AW'(valid_q), 1);
  endtask

  task automatic t_deselect;
    cyc(0, 1, 0, 0, 0, 19'h0_0001);
    chk("R5 valid", AW'(valid_q), 0);
    chk("R5 addr held", addr_q, 19'h3_0F0E);
    cyc(0, 0, 1, 1, 1, 19'h0);
    chk("R6 no advance when invalid", addr_q, 19'h3_0F0E);
  endtask

  task automatic t_order(input logic m, input logic [AW-1:0] start, input string req);
    logic [1:0] s, lo;
    s = start[1:0];
    mode = m;
    cyc(1, 0, 1, 1, 0, start);
    for (int k = 1; k <= 4; k++) begin
      cyc(0, 0, 1, 1, 0, 19'h0);
      chk("R6 hold without adv", addr_q[1:0], AW'(k == 1 ? s : lo));
      cyc(0, 0, 1, 1, 1, 19'h0);
      lo = m ? (s ^ 2'(k)) : 2'(s + 2'(k));
      chk(req, AW'(addr_q[1:0]), AW'(lo));
      chk("R9 upper", AW'(addr_q[AW-1:2]), AW'(start[AW-1:2]));
      chk("R10 last", AW'(last_q), AW'(k == 3));
    end
  endtask

  task automatic t_priority;
    mode = 0;
    cyc(1, 0, 1, 1, 0, 19'h0_0102);
    cyc(0, 1, 1, 1, 1, 19'h0_0201);
    chk("R6 strobe over adv", addr_q, 19'h0_0201);
    cyc(0, 0, 1, 1, 1, 19'h0); cyc(0, 0, 1, 1, 1, 19'h0); cyc(0, 0, 1, 1, 1, 19'h0);
    chk("R10 last set", AW'(last_q), 1);
    cyc(1, 0, 1, 1, 1, 19'h0_0203);
    chk("R10 load clears last", AW'(last_q), 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_cpu_load();
        t_cpu_gated();
        t_ctl_load();
        t_deselect();
        t_order(0, 19'h5_5551, "R7 linear");
        t_order(1, 19'h2_AAA1, "R8 interleaved");
        t_order(1, 19'h0_7FFE, "R8 interleaved start 2");
        t_order(0, 19'h7_0003, "R7 linear start 3");
        t_priority();
      end
      begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule